// File: doc/BRIEF.md
# CPU Bus Snoop Cycle Generator

This block runs an address-only snoop on the CPU bus for each system-memory fetch made on behalf of a PCI master. Each snoop drives the snooped address and pulses the transfer-start strobe (`ts_n`) for one CPU clock. A one-cycle gap follows, then a one-cycle address-acknowledge pulse (`aack_n`). The retry input `artry_n` is sampled only inside a fixed window. If a cache asserts it in that window, the block emits a one-cycle `snoop_hit` pulse together with the snooped address.

The block runs on the CPU clock, which is twice the PCI clock. `pci_phase` is high in each CPU cycle whose closing edge is also a rising PCI edge. The PCI-side strobes are acted on only in those cycles:

- `xfer_begin` gives the block ownership of the CPU address bus.
- `xfer_end` marks the edge on which the target's TRDY# goes to tri-state.

At the end edge, the arbiter input `keep_grant` decides what happens next. If it is high, the block keeps ownership. If it is low, the block releases the bus: the address-select and address-output-enable strobes go high and the AACK# driver is turned off.

A snoop request that arrives while a snoop is running is held, one deep. It starts in the cycle right after the running snoop's acknowledge cycle.

Top module: `snoop_gen`

## Requirements
- R1: A snoop lasts three CPU cycles. `ts_n` is low for exactly the first cycle, the second cycle has neither strobe low, and `aack_n` is low for exactly the third cycle. A request accepted at edge k puts `ts_n` low in the cycle that begins at edge k.
- R2: From the `ts_n` cycle through the `aack_n` cycle, `cpu_addr` holds the accepted request address and `addr_oe_n` is low.
- R3: If `artry_n` is sampled low at the end of the gap cycle or at the end of the acknowledge cycle, `snoop_hit` is high for exactly the one cycle after the acknowledge cycle. In that cycle, `hit_addr` equals the snooped address.
- R4: If `artry_n` is low only at the end of the `ts_n` cycle, or only after the acknowledge cycle, no hit is reported.
- R5: When `xfer_end` is taken with `keep_grant` high, `addr_sel_n` and `addr_oe_n` stay low and `aack_oe` stays 1, so `aack_n` remains driven high.
- R6: When `xfer_end` is taken with `keep_grant` low, then from the next cycle `addr_sel_n` and `addr_oe_n` are high and `aack_oe` is 0.
- R7: `xfer_begin` and `xfer_end` take effect only at an edge where `pci_phase` is 1. At other edges they change nothing. A taken `xfer_begin` makes `addr_sel_n` and `addr_oe_n` low and `aack_oe` 1 from the next cycle.
- R8: `snoop_req` is ignored while the block does not own the address bus: no `ts_n` pulse follows.
- R9: A request accepted during the `ts_n`, gap or acknowledge cycle is held. Its `ts_n` cycle is the cycle right after the current acknowledge cycle, and it carries the held address.
- R10: While `rst_n` is low at a clock edge, the block returns to: `ts_n`=1, `aack_n`=1, `addr_sel_n`=1, `addr_oe_n`=1, `aack_oe`=0, `snoop_hit`=0, no ownership and no held request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pci_phase | input | 1 | High in CPU cycles that end on a rising PCI clock edge |
| xfer_begin | input | 1 | PCI master's memory transaction starts; take the address bus |
| xfer_end | input | 1 | Target TRDY# is tri-stated on this edge; apply the grant decision |
| keep_grant | input | 1 | Arbiter decision at `xfer_end`: 1 keeps ownership, 0 releases it |
| snoop_req | input | 1 | One-cycle request for a snoop of `snoop_addr` |
| snoop_addr | input | ADDR_W | Translated PCI address to snoop |
| artry_n | input | 1 | Cache retry response, active low |
| ts_n | output | 1 | Transfer-start strobe, active low |
| aack_n | output | 1 | Address acknowledge, active low |
| aack_oe | output | 1 | Output enable for the `aack_n` driver (0 = tri-state) |
| addr_sel_n | output | 1 | Address-select strobe, active low while owned |
| addr_oe_n | output | 1 | CPU address output enable, active low while owned |
| cpu_addr | output | ADDR_W | Address driven onto the CPU address bus |
| snoop_hit | output | 1 | One-cycle pulse reporting a hit |
| hit_addr | output | ADDR_W | Address of the most recent snoop that hit |

## Verification
The embedded properties check on every cycle that each strobe lasts one cycle and that the acknowledge lands two cycles after the start. They also check that the address stays still and enabled through a snoop, that a hit pulse lasts one cycle and directly follows an acknowledge, and that a held request starts at once. They further check what the grant decision does and that off-phase PCI strobes have no effect. Only the bench scenarios can show the exact edges of the retry window, where a retry asserted one cycle early or one cycle late must give no hit. The same applies to the address reported with a hit and to requests being ignored while the bus is not owned.

// File: rtl/snoop_gen_pkg.sv
// Shared types for the snoop cycle generator.
package snoop_gen_pkg;

    // Position within one snoop: idle, start strobe, retry gap, acknowledge.
    typedef enum logic [1:0] {
        SN_IDLE = 2'd0,
        SN_TS   = 2'd1,
        SN_GAP  = 2'd2,
        SN_ACK  = 2'd3
    } snoop_state_t;

endpackage

// File: rtl/snoop_own.sv
// Address-bus ownership tracker.
// Takes the bus when a begin strobe lands on a PCI-aligned edge. On a
// PCI-aligned end strobe, releases the bus unless the arbiter says keep.
// Assumes begin and end are never both asserted in the same cycle.
module snoop_own (
    input  logic clk,
    input  logic rst_n,
    input  logic pci_phase,
    input  logic xfer_begin,
    input  logic xfer_end,
    input  logic keep_grant,
    output logic owned
);

    logic end_take;
    logic begin_take;

    assign end_take   = pci_phase && xfer_end && owned;
    assign begin_take = pci_phase && xfer_begin;

    // Ownership register: the release decision wins over a new begin.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owned <= 1'b0;
        end else if (end_take && !keep_grant) begin
            owned <= 1'b0;
        end else if (begin_take) begin
            owned <= 1'b1;
        end
    end

    AST_KEEP_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (end_take && keep_grant) |=> owned); // R5
    AST_LOSE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (end_take && !keep_grant) |=> !owned); // R6
    AST_PHASE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        !pci_phase |=> (owned == $past(owned))); // R7

endmodule

// File: rtl/snoop_seq.sv
// Snoop sequencer.
// Steps each accepted request through start, gap and acknowledge cycles,
// and keeps a one-deep hold slot for a request that arrives mid-snoop.
// Assumes the requester never offers a second request while one is held.
module snoop_seq
    import snoop_gen_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              owned,
    input  logic              req,
    input  logic [ADDR_W-1:0] req_addr,
    output snoop_state_t      state,
    output logic [ADDR_W-1:0] cur_addr
);

    logic              accept;
    logic              held;
    logic [ADDR_W-1:0] held_addr;

    assign accept = req && owned;

    // Snoop position and the address under snoop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= SN_IDLE;
            cur_addr <= '0;
        end else begin
            case (state)
                SN_IDLE: begin
                    if (accept) begin
                        state    <= SN_TS;
                        cur_addr <= req_addr;
                    end
                end
                SN_TS:  state <= SN_GAP;
                SN_GAP: state <= SN_ACK;
                SN_ACK: begin
                    if (held) begin
                        state    <= SN_TS;
                        cur_addr <= held_addr;
                    end else if (accept) begin
                        state    <= SN_TS;
                        cur_addr <= req_addr;
                    end else begin
                        state <= SN_IDLE;
                    end
                end
                default: state <= SN_IDLE;
            endcase
        end
    end

    // One-deep hold slot for requests that arrive while a snoop runs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held      <= 1'b0;
            held_addr <= '0;
        end else begin
            case (state)
                SN_TS, SN_GAP: begin
                    if (accept && !held) begin
                        held      <= 1'b1;
                        held_addr <= req_addr;
                    end
                end
                SN_ACK: begin
                    if (held) begin
                        held <= accept;
                        if (accept) begin
                            held_addr <= req_addr;
                        end
                    end
                end
                default: held <= 1'b0;
            endcase
        end
    end

    AST_TS_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SN_TS) |=> (state == SN_GAP)); // R1
    AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SN_ACK) |=> (state != SN_ACK)); // R1
    AST_ADDR_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SN_GAP || state == SN_ACK) |-> $stable(cur_addr)); // R2
    AST_HELD_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SN_ACK && held) |=> (state == SN_TS)); // R9

endmodule

// File: rtl/snoop_hit_det.sv
// Retry window checker.
// Samples the retry input at the end of the gap cycle and at the end of
// the acknowledge cycle only. Reports a hit as a one-cycle pulse in the
// cycle after the acknowledge, together with the snooped address.
module snoop_hit_det
    import snoop_gen_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  snoop_state_t      state,
    input  logic              artry_n,
    input  logic [ADDR_W-1:0] cur_addr,
    output logic              snoop_hit,
    output logic [ADDR_W-1:0] hit_addr
);

    logic seen;
    logic hit_now;

    assign hit_now = (state == SN_ACK) && (seen || !artry_n);

    // Retry seen at the first window edge (end of the gap cycle).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen <= 1'b0;
        end else if (state == SN_TS) begin
            seen <= 1'b0;
        end else if (state == SN_GAP) begin
            seen <= !artry_n;
        end
    end

    // Hit pulse and captured address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snoop_hit <= 1'b0;
            hit_addr  <= '0;
        end else begin
            snoop_hit <= hit_now;
            if (hit_now) begin
                hit_addr <= cur_addr;
            end
        end
    end

    AST_HIT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        snoop_hit |=> !snoop_hit); // R3
    AST_HIT_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        snoop_hit |-> ($past(state) == SN_ACK)); // R3

endmodule

// File: rtl/snoop_gen.sv
// CPU bus snoop cycle generator (top).
// Joins ownership tracking, the snoop sequencer and the retry window
// checker, and forms the active-low bus strobes. Runs on the CPU clock.
// Assumes a 2:1 CPU-to-PCI clock ratio, marked by pci_phase, and that
// no release is requested while a snoop is running or held.
module snoop_gen
    import snoop_gen_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pci_phase,
    input  logic              xfer_begin,
    input  logic              xfer_end,
    input  logic              keep_grant,
    input  logic              snoop_req,
    input  logic [ADDR_W-1:0] snoop_addr,
    input  logic              artry_n,
    output logic              ts_n,
    output logic              aack_n,
    output logic              aack_oe,
    output logic              addr_sel_n,
    output logic              addr_oe_n,
    output logic [ADDR_W-1:0] cpu_addr,
    output logic              snoop_hit,
    output logic [ADDR_W-1:0] hit_addr
);

    logic         owned;
    snoop_state_t state;

    snoop_own u_own (
        .clk        (clk),
        .rst_n      (rst_n),
        .pci_phase  (pci_phase),
        .xfer_begin (xfer_begin),
        .xfer_end   (xfer_end),
        .keep_grant (keep_grant),
        .owned      (owned)
    );

    snoop_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .owned    (owned),
        .req      (snoop_req),
        .req_addr (snoop_addr),
        .state    (state),
        .cur_addr (cpu_addr)
    );

    snoop_hit_det #(.ADDR_W(ADDR_W)) u_hit (
        .clk       (clk),
        .rst_n     (rst_n),
        .state     (state),
        .artry_n   (artry_n),
        .cur_addr  (cpu_addr),
        .snoop_hit (snoop_hit),
        .hit_addr  (hit_addr)
    );

    // Bus strobes decoded from the registered state.
    always_comb begin
        ts_n       = (state != SN_TS);
        aack_n     = (state != SN_ACK);
        aack_oe    = owned;
        addr_sel_n = !owned;
        addr_oe_n  = !owned;
    end

    AST_OE_IN_SNOOP: assert property (@(posedge clk) disable iff (!rst_n)
        (!ts_n || !aack_n) |-> !addr_oe_n); // R2
    AST_ACK_FOLLOWS_TS: assert property (@(posedge clk) disable iff (!rst_n)
        !aack_n |-> !$past(ts_n, 2)); // R1

endmodule

// File: tb/tb_snoop_gen.sv
module tb_snoop_gen;

    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          pci_phase;
    logic          xfer_begin;
    logic          xfer_end;
    logic          keep_grant;
    logic          snoop_req;
    logic [AW-1:0] snoop_addr;
    logic          artry_n;
    logic          ts_n;
    logic          aack_n;
    logic          aack_oe;
    logic          addr_sel_n;
    logic          addr_oe_n;
    logic [AW-1:0] cpu_addr;
    logic          snoop_hit;
    logic [AW-1:0] hit_addr;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  done = 1'b0;
    bit  chk_en = 1'b0;

    // Reference model state, computed from the requirements.
    int          m_ph = 0;       // 0 idle, 1 start, 2 gap, 3 acknowledge
    bit          m_pend = 0;
    bit          m_own = 0;
    bit          m_hit = 0;
    bit          m_seen = 0;
    bit          m_take = 0;
    logic [AW-1:0] m_addr = '0;
    logic [AW-1:0] m_paddr = '0;
    logic [AW-1:0] m_haddr = '0;

    always #10 clk = ~clk;   // 50 MHz

    snoop_gen #(.ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .pci_phase(pci_phase),
        .xfer_begin(xfer_begin), .xfer_end(xfer_end), .keep_grant(keep_grant),
        .snoop_req(snoop_req), .snoop_addr(snoop_addr), .artry_n(artry_n),
        .ts_n(ts_n), .aack_n(aack_n), .aack_oe(aack_oe),
        .addr_sel_n(addr_sel_n), .addr_oe_n(addr_oe_n), .cpu_addr(cpu_addr),
        .snoop_hit(snoop_hit), .hit_addr(hit_addr)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s at %0t: actual=%0h expected=%0h", req, $time, act, exp);
        end
    endtask

    // Advance one cycle; pci_phase is high every other cycle.
    task automatic tick();
        @(negedge clk);
        pci_phase = ~pci_phase;
    endtask

    // Reference model update at each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_pend = 0; m_own = 0; m_hit = 0; m_seen = 0;
            m_addr = '0; m_paddr = '0; m_haddr = '0;
        end else begin
            m_take = snoop_req && m_own;
            if (m_ph == 3 && (m_seen || !artry_n)) begin
                m_hit = 1; m_haddr = m_addr;
            end else begin
                m_hit = 0;
            end
            if (m_ph == 1) m_seen = 0;
            else if (m_ph == 2) m_seen = !artry_n;
            case (m_ph)
                0: if (m_take) begin m_ph = 1; m_addr = snoop_addr; end
                1, 2: begin
                    m_ph = m_ph + 1;
                    if (m_take && !m_pend) begin m_pend = 1; m_paddr = snoop_addr; end
                end
                default: begin
                    if (m_pend) begin
                        m_ph = 1; m_addr = m_paddr; m_pend = m_take;
                        if (m_take) m_paddr = snoop_addr;
                    end else if (m_take) begin
                        m_ph = 1; m_addr = snoop_addr;
                    end else begin
                        m_ph = 0;
                    end
                end
            endcase
            if (pci_phase && xfer_end && m_own && !keep_grant) m_own = 0;
            else if (pci_phase && xfer_begin) m_own = 1;
        end
    end

    // Cycle-by-cycle comparison against the model, away from the clock edge.
    always @(negedge clk) begin
        if (chk_en) begin
            chk(ts_n === (m_ph != 1), "R1 ts_n", ts_n, m_ph != 1);
            chk(aack_n === (m_ph != 3), "R1 aack_n", aack_n, m_ph != 3);
            chk(addr_oe_n === !m_own, "R6 addr_oe_n", addr_oe_n, !m_own);
            chk(addr_sel_n === !m_own, "R6 addr_sel_n", addr_sel_n, !m_own);
            chk(aack_oe === m_own, "R5 aack_oe", aack_oe, m_own);
            if (m_ph != 0) chk(cpu_addr === m_addr, "R2 cpu_addr", cpu_addr, m_addr);
            chk(snoop_hit === m_hit, "R3 snoop_hit", snoop_hit, m_hit);
            if (m_hit) chk(hit_addr === m_haddr, "R3 hit_addr", hit_addr, m_haddr);
        end
    end

    task automatic strobe_begin(input bit ph);
        do tick(); while (pci_phase != ph);
        xfer_begin = 1'b1;
        tick();
        xfer_begin = 1'b0;
    endtask

    task automatic strobe_end(input bit ph, input bit keep);
        do tick(); while (pci_phase != ph);
        xfer_end = 1'b1;
        keep_grant = keep;
        tick();
        xfer_end = 1'b0;
    endtask

    // One snoop with artry_n low for the single cycle at offset off from the start cycle.
    task automatic window_run(input int off, input logic [AW-1:0] a);
        tick();
        snoop_req = 1'b1;
        snoop_addr = a;
        for (int i = 1; i <= 6; i++) begin
            tick();
            if (i == 1) begin
                snoop_req = 1'b0;
                chk(ts_n === 1'b0, "R1 start pulse", ts_n, 0);
                chk(cpu_addr === a, "R2 address", cpu_addr, a);
            end
            if (i == 2) chk(ts_n === 1'b1 && aack_n === 1'b1, "R1 gap", {ts_n, aack_n}, 2'b11);
            if (i == 3) chk(aack_n === 1'b0, "R1 ack pulse", aack_n, 0);
            if (i == 4) begin
                if (off == 1 || off == 2) begin
                    chk(snoop_hit === 1'b1, "R3 window hit", snoop_hit, 1);
                    chk(hit_addr === a, "R3 hit address", hit_addr, a);
                end else begin
                    chk(snoop_hit === 1'b0, "R4 outside window", snoop_hit, 0);
                end
            end
            if (i == 5) chk(snoop_hit === 1'b0, "R3 pulse width", snoop_hit, 0);
            artry_n = !(i == 1 + off);
        end
        artry_n = 1'b1;
    endtask

    initial begin
        int seed_val;
        seed_val = $urandom(32'h5EED_0042);
        rst_n = 1'b0; pci_phase = 1'b0; xfer_begin = 1'b0; xfer_end = 1'b0;
        keep_grant = 1'b0; snoop_req = 1'b0; snoop_addr = '0; artry_n = 1'b1;
        repeat (3) tick();
        chk({ts_n, aack_n, addr_sel_n, addr_oe_n, aack_oe, snoop_hit} === 6'b111100,
            "R10 reset", {ts_n, aack_n, addr_sel_n, addr_oe_n, aack_oe, snoop_hit}, 6'b111100);
        rst_n = 1'b1;
        chk_en = 1'b1;

        // R8: request without ownership is ignored.
        tick(); snoop_req = 1'b1; snoop_addr = 32'h1111_0000;
        tick(); snoop_req = 1'b0;
        chk(ts_n === 1'b1, "R8 ignored request", ts_n, 1);
        tick();
        chk(ts_n === 1'b1 && aack_n === 1'b1, "R8 no snoop", {ts_n, aack_n}, 2'b11);

        // R7: begin off-phase does nothing, on-phase takes the bus.
        strobe_begin(1'b0);
        chk(addr_sel_n === 1'b1, "R7 off-phase begin", addr_sel_n, 1);
        strobe_begin(1'b1);
        chk(addr_sel_n === 1'b0 && aack_oe === 1'b1, "R7 on-phase begin",
            {addr_sel_n, aack_oe}, 2'b01);

        // R3/R4: retry window boundaries.
        for (int off = 0; off < 4; off++) window_run(off, 32'hA000_0000 + off);

        // R9: request held during a snoop starts right after acknowledge.
        tick(); snoop_req = 1'b1; snoop_addr = 32'hB0B0_0001;
        tick(); snoop_req = 1'b0;
        tick(); snoop_req = 1'b1; snoop_addr = 32'hB0B0_0002;
        tick(); snoop_req = 1'b0;
        chk(aack_n === 1'b0, "R9 first ack", aack_n, 0);
        tick();
        chk(ts_n === 1'b0 && cpu_addr === 32'hB0B0_0002, "R9 held start", cpu_addr, 32'hB0B0_0002);
        repeat (4) tick();

        // R5: end with keep; R7: end off-phase; R6: end with release.
        strobe_end(1'b1, 1'b1);
        chk(addr_sel_n === 1'b0 && addr_oe_n === 1'b0 && aack_oe === 1'b1 && aack_n === 1'b1,
            "R5 keep grant", {addr_sel_n, addr_oe_n, aack_oe}, 3'b001);
        strobe_end(1'b0, 1'b0);
        chk(addr_sel_n === 1'b0, "R7 off-phase end", addr_sel_n, 0);
        strobe_end(1'b1, 1'b0);
        chk(addr_sel_n === 1'b1 && addr_oe_n === 1'b1 && aack_oe === 1'b0,
            "R6 lose grant", {addr_sel_n, addr_oe_n, aack_oe}, 3'b110);

        // Constrained random traffic against the model.
        for (int cyc = 0; cyc < 4000; cyc++) begin
            tick();
            snoop_req = 1'b0; xfer_begin = 1'b0; xfer_end = 1'b0;
            artry_n = ($urandom_range(0, 2) != 0);
            keep_grant = $urandom_range(0, 1);
            snoop_addr = $urandom;
            if (!m_own) begin
                xfer_begin = ($urandom_range(0, 3) == 0);
                snoop_req = ($urandom_range(0, 5) == 0);
            end else if (m_ph == 0 && !m_pend && $urandom_range(0, 9) == 0) begin
                xfer_end = 1'b1;
            end else if (!m_pend || m_ph == 3) begin
                snoop_req = ($urandom_range(0, 2) == 0);
            end
        end
        tick();
        snoop_req = 1'b0; xfer_begin = 1'b0; xfer_end = 1'b0; artry_n = 1'b1;
        repeat (10) tick();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule